// File: doc/BRIEF.md
# Store-Conditional Reservation Checker

This block holds the single load-reserve reservation of a processor core and rules on each conditional store. A reserve request records an address and an access size; a later conditional store presents its effective address, its extended opcode (which fixes the access size) and the current summary-overflow bit. One cycle later the block returns a done strobe, a success flag, a 4-bit condition field for the condition register and a memory write enable that is raised only for a store that succeeded.

Every conditional store that is decoded consumes the reservation, win or lose. A clear input lets snoop hits from other agents or a context switch drop the reservation. When a reserve and a conditional store arrive together, the store is judged against the reservation that existed before that cycle and the new one is installed afterwards.

Top module: `stc_reservation`

## Requirements
- R1: After reset the reservation is invalid, and done_o, ok_o, cr_o and mem_we_o are all zero; a conditional store issued right after reset fails, even to address zero.
- R2: With sc_req_i high, sc_xop_i values 694, 726, 150 and 214 select byte (size code 0), halfword (1), word (2) and doubleword (3) conditional stores; any other value is ignored: no done strobe and the reservation is kept.
- R3: A decoded conditional store succeeds only if the reservation is valid, its recorded size code equals the store's size code and its recorded address equals sc_ea_i.
- R4: When done_o is high, cr_o equals {2'b00, success, summary-overflow}: bit 1 carries the success bit and bit 0 carries sc_so_i sampled with the request; bits 3 and 2 are zero.
- R5: Every decoded conditional store, successful or not, leaves the reservation invalid, unless a reserve is presented in the same cycle.
- R6: mem_we_o is high exactly when done_o and ok_o are both high.
- R7: A reserve request (rsv_req_i) records rsv_addr_i and size code rsv_size_i (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 bytes) and replaces any older reservation.
- R8: clr_i makes the reservation invalid from the next cycle on; it takes priority over a reserve presented in the same cycle.
- R9: A reserve and a conditional store in the same cycle: the store is judged against the old reservation and the new one is valid afterwards.
- R10: done_o, ok_o, cr_o and mem_we_o are registered: done_o is high for exactly the one cycle after a decoded request, and all four are zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Drop the reservation (snoop hit or context switch) |
| rsv_req_i | input | 1 | Load-reserve request |
| rsv_addr_i | input | ADDR_W | Address to reserve |
| rsv_size_i | input | 2 | Size code of the reserve |
| sc_req_i | input | 1 | Conditional store request |
| sc_xop_i | input | XOP_W | Extended opcode of the store |
| sc_ea_i | input | ADDR_W | Effective address of the store |
| sc_so_i | input | 1 | Current summary-overflow bit |
| done_o | output | 1 | Result strobe, one cycle after a decoded request |
| ok_o | output | 1 | Store performed |
| cr_o | output | 4 | Condition field |
| mem_we_o | output | 1 | Memory write enable |

## Verification
The hardest situations to reach are the same-cycle collisions: a reserve arriving together with a conditional store, and a clear arriving together with a reserve, because each decides which reservation a later store sees. Directed sequences build these collisions one at a time and then probe the resulting state with a follow-up store whose success or failure exposes it. A pseudo-random phase draws addresses and sizes from a tiny pool so that matches, size mismatches and collisions of all three inputs occur often, with a behavioural model checking every cycle.

// File: rtl/stc_pkg.sv
package stc_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DWRD = 2'd3
   } stc_size_e;

   localparam int unsigned NUM_SIZES = 4;

   // condition field: bit 1 = performed, bit 0 = summary overflow
   function automatic logic [3:0] make_cond(input logic performed, input logic so);
      return {2'b00, performed, so};
   endfunction
endpackage

// File: rtl/stc_xop_decode.sv
module stc_xop_decode
   import stc_pkg::*;
#(
   parameter int unsigned XOP_W    = 10,
   parameter int unsigned XOP_BYTE = 694,
   parameter int unsigned XOP_HALF = 726,
   parameter int unsigned XOP_WORD = 150,
   parameter int unsigned XOP_DWRD = 214
) (
   input  logic             req_i,
   input  logic [XOP_W-1:0] xop_i,
   output logic             go_o,
   output stc_size_e        size_o
);
   localparam int unsigned XOP_MAX = (1 << XOP_W) - 1;
   localparam int unsigned TBL [NUM_SIZES] = '{XOP_BYTE, XOP_HALF, XOP_WORD, XOP_DWRD};

   logic [NUM_SIZES-1:0] hit;

   for (genvar i = 0; i < NUM_SIZES; i++) begin : g_tbl
      if (TBL[i] > XOP_MAX) begin : g_range_err
         $error("stc_xop_decode: opcode %0d does not fit in XOP_W", TBL[i]);
      end
      for (genvar j = i + 1; j < NUM_SIZES; j++) begin : g_uniq
         if (TBL[i] == TBL[j]) begin : g_dup_err
            $error("stc_xop_decode: opcodes %0d and %0d collide", i, j);
         end
      end
      assign hit[i] = req_i && (xop_i == XOP_W'(TBL[i]));
   end

   always_comb begin
      size_o = SZ_BYTE;
      for (int i = 0; i < NUM_SIZES; i++) begin
         if (hit[i]) size_o = stc_size_e'(i);
      end
   end

   assign go_o = |hit;
endmodule

// File: rtl/stc_resv_reg.sv
module stc_resv_reg
   import stc_pkg::*;
#(
   parameter int unsigned ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              set_i,
   input  logic [ADDR_W-1:0] set_addr_i,
   input  stc_size_e         set_size_i,
   input  logic              consume_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o,
   output stc_size_e         size_o
);
   // priority: clear, then new reservation, then consumption by a store
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         addr_o  <= '0;
         size_o  <= SZ_BYTE;
      end else if (clr_i) begin
         valid_o <= 1'b0;
      end else if (set_i) begin
         valid_o <= 1'b1;
         addr_o  <= set_addr_i;
         size_o  <= set_size_i;
      end else if (consume_i) begin
         valid_o <= 1'b0;
      end
   end
endmodule

// File: rtl/stc_match.sv
module stc_match
   import stc_pkg::*;
#(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned CHUNK_W = 16
) (
   input  logic              valid_i,
   input  logic [ADDR_W-1:0] resv_addr_i,
   input  stc_size_e         resv_size_i,
   input  logic [ADDR_W-1:0] ea_i,
   input  stc_size_e         st_size_i,
   output logic              hit_o
);
   logic addr_eq;

   if (CHUNK_W == 0) begin : g_chunk_err
      $error("stc_match: CHUNK_W must be nonzero");
   end else if (CHUNK_W >= ADDR_W) begin : g_flat
      assign addr_eq = (resv_addr_i == ea_i);
   end else begin : g_split
      localparam int unsigned NCHUNK = ADDR_W / CHUNK_W;
      if (NCHUNK * CHUNK_W != ADDR_W) begin : g_div_err
         $error("stc_match: ADDR_W must be a multiple of CHUNK_W");
      end
      logic [NCHUNK-1:0] part_eq;
      for (genvar c = 0; c < NCHUNK; c++) begin : g_part
         assign part_eq[c] = (resv_addr_i[c*CHUNK_W +: CHUNK_W] == ea_i[c*CHUNK_W +: CHUNK_W]);
      end
      assign addr_eq = &part_eq;
   end

   assign hit_o = valid_i && (resv_size_i == st_size_i) && addr_eq;
endmodule

// File: rtl/stc_reservation.sv
module stc_reservation
   import stc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned CHUNK_W  = 16,
   parameter int unsigned XOP_W    = 10,
   parameter int unsigned XOP_BYTE = 694,
   parameter int unsigned XOP_HALF = 726,
   parameter int unsigned XOP_WORD = 150,
   parameter int unsigned XOP_DWRD = 214
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              rsv_req_i,
   input  logic [ADDR_W-1:0] rsv_addr_i,
   input  logic [1:0]        rsv_size_i,
   input  logic              sc_req_i,
   input  logic [XOP_W-1:0]  sc_xop_i,
   input  logic [ADDR_W-1:0] sc_ea_i,
   input  logic              sc_so_i,
   output logic              done_o,
   output logic              ok_o,
   output logic [3:0]        cr_o,
   output logic              mem_we_o
);
   if (ADDR_W < 2) begin : g_addr_err
      $error("stc_reservation: ADDR_W too small");
   end

   logic              sc_go;
   stc_size_e         sc_size;
   logic              resv_valid;
   logic [ADDR_W-1:0] resv_addr;
   stc_size_e         resv_size;
   logic              sc_hit;

   stc_xop_decode #(
      .XOP_W(XOP_W), .XOP_BYTE(XOP_BYTE), .XOP_HALF(XOP_HALF),
      .XOP_WORD(XOP_WORD), .XOP_DWRD(XOP_DWRD)
   ) u_dec (
      .req_i (sc_req_i),
      .xop_i (sc_xop_i),
      .go_o  (sc_go),
      .size_o(sc_size)
   );

   stc_resv_reg #(.ADDR_W(ADDR_W)) u_resv (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr_i),
      .set_i     (rsv_req_i),
      .set_addr_i(rsv_addr_i),
      .set_size_i(stc_size_e'(rsv_size_i)),
      .consume_i (sc_go),
      .valid_o   (resv_valid),
      .addr_o    (resv_addr),
      .size_o    (resv_size)
   );

   stc_match #(.ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W)) u_match (
      .valid_i    (resv_valid),
      .resv_addr_i(resv_addr),
      .resv_size_i(resv_size),
      .ea_i       (sc_ea_i),
      .st_size_i  (sc_size),
      .hit_o      (sc_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o   <= 1'b0;
         ok_o     <= 1'b0;
         cr_o     <= 4'b0000;
         mem_we_o <= 1'b0;
      end else begin
         done_o   <= sc_go;
         ok_o     <= sc_go && sc_hit;
         cr_o     <= sc_go ? make_cond(sc_hit, sc_so_i) : 4'b0000;
         mem_we_o <= sc_go && sc_hit;
      end
   end
endmodule

// File: rtl/stc_checker.sv
module stc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       clr_i,
   input logic       rsv_req_i,
   input logic       sc_so_i,
   input logic       sc_go,
   input logic       resv_valid,
   input logic       done_o,
   input logic       ok_o,
   input logic [3:0] cr_o,
   input logic       mem_we_o
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> !resv_valid && !done_o && !mem_we_o);

   assert_ok_needs_resv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sc_go && !resv_valid |=> done_o && !ok_o);

   assert_cond_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sc_go |=> cr_o == {2'b00, ok_o, $past(sc_so_i)});

   assert_consume_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sc_go && !rsv_req_i |=> !resv_valid);

   assert_we_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o == (done_o && ok_o));

   assert_install_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_req_i && !clr_i |=> resv_valid);

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !resv_valid);

   assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sc_go |=> !done_o && !ok_o && cr_o == 4'b0000);
endmodule

bind stc_reservation stc_checker u_stc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_i     (clr_i),
   .rsv_req_i (rsv_req_i),
   .sc_so_i   (sc_so_i),
   .sc_go     (sc_go),
   .resv_valid(resv_valid),
   .done_o    (done_o),
   .ok_o      (ok_o),
   .cr_o      (cr_o),
   .mem_we_o  (mem_we_o)
);

// File: tb/test_stc_reservation.sv
`timescale 1ns/1ps
module test_stc_reservation;
   localparam int AW = 64;
   localparam time CLK_P = 10ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr_i = 1'b0;
   logic          rsv_req_i = 1'b0;
   logic [AW-1:0] rsv_addr_i = '0;
   logic [1:0]    rsv_size_i = '0;
   logic          sc_req_i = 1'b0;
   logic [9:0]    sc_xop_i = '0;
   logic [AW-1:0] sc_ea_i = '0;
   logic          sc_so_i = 1'b0;
   logic          done_o, ok_o, mem_we_o;
   logic [3:0]    cr_o;

   int checks = 0;
   int errors = 0;

   // reference reservation
   bit            m_valid = 0;
   logic [AW-1:0] m_addr = '0;
   int            m_size = 0;

   always #(CLK_P/2) clk = ~clk;

   stc_reservation i_stc_reservation (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
      .rsv_req_i(rsv_req_i), .rsv_addr_i(rsv_addr_i), .rsv_size_i(rsv_size_i),
      .sc_req_i(sc_req_i), .sc_xop_i(sc_xop_i), .sc_ea_i(sc_ea_i), .sc_so_i(sc_so_i),
      .done_o(done_o), .ok_o(ok_o), .cr_o(cr_o), .mem_we_o(mem_we_o)
   );

   localparam logic [9:0] OP_B = 10'd694, OP_H = 10'd726, OP_W = 10'd150, OP_D = 10'd214;

   function automatic int op_size(input logic [9:0] xop);
      case (xop)
         10'd694: return 0;
         10'd726: return 1;
         10'd150: return 2;
         10'd214: return 3;
         default: return -1;
      endcase
   endfunction

   task automatic compare(input string tag, input logic [6:0] act, input logic [6:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s done/ok/cr/we actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // one clock: drive at negedge, update model, compare at next negedge
   task automatic cyc(input string tag, input logic clr, input logic rv,
                      input logic [AW-1:0] ra, input logic [1:0] rs,
                      input logic sc, input logic [9:0] xop,
                      input logic [AW-1:0] ea, input logic so);
      int  sz;
      bit  go, hit;
      logic [6:0] exp;
      clr_i = clr; rsv_req_i = rv; rsv_addr_i = ra; rsv_size_i = rs;
      sc_req_i = sc; sc_xop_i = xop; sc_ea_i = ea; sc_so_i = so;
      sz  = op_size(xop);
      go  = sc && (sz >= 0);
      hit = go && m_valid && (m_size == sz) && (m_addr == ea);
      exp = {go, hit, go ? {2'b00, hit, so} : 4'b0000, hit};
      if (clr) m_valid = 0;
      else if (rv) begin m_valid = 1; m_addr = ra; m_size = int'(rs); end
      else if (go) m_valid = 0;
      @(posedge clk);
      @(negedge clk);
      compare(tag, {done_o, ok_o, cr_o, mem_we_o}, exp);
   endtask

   task automatic idle(input string tag);
      cyc(tag, 0, 0, '0, 0, 0, 10'd0, '0, 0);
   endtask
   task automatic rsv(input string tag, input logic [AW-1:0] a, input logic [1:0] s);
      cyc(tag, 0, 1, a, s, 0, 10'd0, '0, 0);
   endtask
   task automatic stc(input string tag, input logic [9:0] xop, input logic [AW-1:0] ea, input logic so);
      cyc(tag, 0, 0, '0, 0, 1, xop, ea, so);
   endtask

   localparam logic [AW-1:0] A = 64'h0000_1000_0000_0040;
   localparam logic [AW-1:0] B = 64'h8000_0000_0000_0040;

   initial begin
      repeat (3) @(negedge clk);
      compare("R1", {done_o, ok_o, cr_o, mem_we_o}, 7'b0);
      rst_n = 1'b1;
      // R1: no reservation after reset, even at address 0 size byte
      stc("R1", OP_B, '0, 0);
      stc("R1", OP_B, '0, 1);
      // R7 / R3 / R4: halfword success, with and without overflow
      rsv("R7", A, 2'd1);
      stc("R3", OP_H, A, 0);
      rsv("R7", A, 2'd1);
      stc("R4", OP_H, A, 1);
      // R5: consumed after success
      stc("R5", OP_H, A, 0);
      // R3: size mismatch fails, then R5 consumed after failure
      rsv("R7", A, 2'd2);
      stc("R3", OP_H, A, 0);
      stc("R5", OP_W, A, 0);
      // R3: address mismatch (high bit only)
      rsv("R7", A, 2'd3);
      stc("R3", OP_D, A ^ 64'h8000_0000_0000_0000, 1);
      // R7: newer reservation replaces older
      rsv("R7", A, 2'd3);
      rsv("R7", B, 2'd3);
      stc("R7", OP_D, A, 0);
      rsv("R7", A, 2'd3);
      rsv("R7", B, 2'd3);
      stc("R7", OP_D, B, 0);
      // R2: unknown opcode ignored, reservation kept
      rsv("R2", A, 2'd0);
      stc("R2", 10'd151, A, 1);
      stc("R2", 10'd215, A, 0);
      stc("R2", OP_B, A, 0);
      // R2: word opcode decodes to size 2
      rsv("R2", B, 2'd2);
      stc("R2", OP_W, B, 1);
      // R8: clear drops reservation; clear beats a same-cycle reserve
      rsv("R8", A, 2'd2);
      cyc("R8", 1, 0, '0, 0, 0, 10'd0, '0, 0);
      stc("R8", OP_W, A, 0);
      cyc("R8", 1, 1, A, 2'd2, 0, 10'd0, '0, 0);
      stc("R8", OP_W, A, 0);
      // R9: reserve + store same cycle
      rsv("R9", A, 2'd2);
      cyc("R9", 0, 1, B, 2'd2, 1, OP_W, A, 0);
      stc("R9", OP_W, B, 0);
      cyc("R9", 0, 1, B, 2'd1, 1, OP_W, A, 1);
      stc("R9", OP_H, B, 0);
      // R10: idle cycles give no strobe
      idle("R10");
      idle("R10");
      // R3 / R6: pseudo-random mix over a tiny pool
      for (int n = 0; n < 600; n++) begin
         logic [AW-1:0] pool [4];
         logic [9:0]    ops [5];
         pool = '{A, B, A ^ 64'h1, 64'h0};
         ops  = '{OP_B, OP_H, OP_W, OP_D, 10'd407};
         cyc("R3", ($urandom_range(0, 9) == 0), ($urandom_range(0, 2) == 0),
             pool[$urandom_range(0, 3)], 2'($urandom_range(0, 3)),
             ($urandom_range(0, 1) == 1), ops[$urandom_range(0, 4)],
             pool[$urandom_range(0, 3)], 1'($urandom_range(0, 1)));
      end
      idle("R6");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule